// File: doc/BRIEF.md
# Load-Protect Alias Detector

This block keeps a small table of byte ranges read by loads that a scheduler has hoisted above earlier stores. A protecting load writes its start address, its access size and a slot tag into the lowest-numbered free entry. A checking store compares its own byte range with every valid entry. If the two ranges share any byte, the block raises an alias fault one cycle later. The fault reports a bit vector of the entries that collide and the tag of the lowest one.

When a store finds no overlap, the value from the earlier load is still good, so a second load of that location can be skipped. Entries can be removed by tag, or all at once in one cycle when a speculative region ends on commit or rollback. A protect request that finds the table full raises an overflow flag and writes nothing.

Top module: `load_alias_table`

## Requirements
- R1: A protect request is written into the lowest-numbered invalid entry. It records the start address, the size code and the tag. Size code c stands for 2^c bytes (0..3 gives 1, 2, 4 or 8 bytes). The entry takes part in checks from the next cycle on.
- R2: One cycle after a check request, `faultValid` is high and `faultHits[i]` is set for every valid entry i whose range overlaps the checked range. Two ranges overlap when storeLo < loadHi and loadLo < storeHi, where Hi = Lo + byte count.
- R3: Ranges that only touch end to end do not fault. A check that does not fault leaves every entry in place, and later checks still hit those entries.
- R4: `faultTag` carries the tag of the lowest-indexed entry in `faultHits`. When there is no fault, `faultHits` and `faultTag` are zero.
- R5: A check is judged against the table as it stood before any protect or clear in the same cycle. A store is never flagged against a load protected in its own cycle.
- R6: `clrAll` invalidates every entry in one cycle. A protect request in the same cycle is discarded.
- R7: A clear-by-tag request invalidates every valid entry that holds the given tag. An entry allocated in that same cycle stays valid, even if it carries the same tag.
- R8: A protect request that finds all entries valid, with no `clrAll` in that cycle, drives `overflow` high for one cycle and changes no entry. Otherwise `overflow` is low.
- R9: Range ends are computed one bit wider than the address, so a range at the top of the address space does not wrap around to match low addresses.
- R10: After reset every entry is invalid and `faultValid`, `faultHits`, `faultTag` and `overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| protValid | input | 1 | Protect request strobe |
| protAddr | input | ADDR_W | Start address of the protected load |
| protSize | input | 2 | Size code of the load (2^code bytes) |
| protTag | input | TAG_W | Slot tag stored with the entry |
| chkValid | input | 1 | Check request strobe |
| chkAddr | input | ADDR_W | Start address of the store |
| chkSize | input | 2 | Size code of the store |
| clrValid | input | 1 | Clear-by-tag strobe |
| clrTag | input | TAG_W | Tag to clear |
| clrAll | input | 1 | Invalidate all entries |
| faultValid | output | 1 | Alias fault, one cycle after the check |
| faultHits | output | NUM_ENT | Entries that overlapped the check |
| faultTag | output | TAG_W | Tag of the lowest overlapping entry |
| overflow | output | 1 | Protect request dropped because the table was full |

## Verification
A check can arrive in the same cycle as a protect, a clear by tag or a clear of all entries. The bench drives such pairs on the same edge. It then requires the fault result to reflect only the table contents from before that edge. Follow-up checks on later cycles confirm the table change that the other operation made. A protect and a clear by tag with the same tag on the same edge are judged the same way: the old entry must be gone and the new one must hit.

// File: rtl/alias_pkg.sv
package alias_pkg;
  localparam int SIZE_W = 2;

  typedef struct packed {
    logic wrEn;
    logic clrAll;
    logic clrTagEn;
    logic chkEn;
  } strobe_t;
endpackage

// File: rtl/alias_ctrl.sv
module alias_ctrl
  import alias_pkg::*;
#(
  parameter int NUM_ENT = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               protValid,
  input  logic               chkValid,
  input  logic               clrValid,
  input  logic               clrAll,
  input  logic [NUM_ENT-1:0] validVec,
  output strobe_t            stb,
  output logic [NUM_ENT-1:0] wrOh,
  output logic               overflow
);
  logic tableFull;
  logic foundFree;

  assign tableFull = &validVec;

  always_comb begin
    wrOh      = '0;
    foundFree = 1'b0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (!validVec[i] && !foundFree) begin
        wrOh[i]   = 1'b1;
        foundFree = 1'b1;
      end
    end
  end

  always_comb begin
    stb.wrEn     = protValid && !tableFull && !clrAll;
    stb.clrAll   = clrAll;
    stb.clrTagEn = clrValid && !clrAll;
    stb.chkEn    = chkValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) overflow <= 1'b0;
    else       overflow <= protValid && tableFull && !clrAll;
  end

  a_r8_overflow_only_when_full: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> $past(&validVec));

  a_r1_alloc_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrOh));

  a_r8_no_write_when_full: assert property (@(posedge clk) disable iff (!rstN)
    tableFull |-> !stb.wrEn);
endmodule

// File: rtl/alias_dp.sv
module alias_dp
  import alias_pkg::*;
#(
  parameter int NUM_ENT = 8,
  parameter int ADDR_W  = 32,
  parameter int TAG_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [NUM_ENT-1:0] wrOh,
  input  logic [ADDR_W-1:0]  protAddr,
  input  logic [SIZE_W-1:0]  protSize,
  input  logic [TAG_W-1:0]   protTag,
  input  logic [ADDR_W-1:0]  chkAddr,
  input  logic [SIZE_W-1:0]  chkSize,
  input  logic [TAG_W-1:0]   clrTag,
  output logic [NUM_ENT-1:0] validVec,
  output logic               faultValid,
  output logic [NUM_ENT-1:0] faultHits,
  output logic [TAG_W-1:0]   faultTag
);
  localparam int EXT_W = ADDR_W + 1;

  function automatic logic [EXT_W-1:0] spanOf(input logic [SIZE_W-1:0] code);
    return EXT_W'(1) << code;
  endfunction

  logic [ADDR_W-1:0] entAddr [NUM_ENT];
  logic [SIZE_W-1:0] entSize [NUM_ENT];
  logic [TAG_W-1:0]  entTag  [NUM_ENT];
  logic [NUM_ENT-1:0] validQ;
  logic [NUM_ENT-1:0] hitVec;
  logic [NUM_ENT-1:0] tagHit;
  logic [EXT_W-1:0]   chkLo, chkHi;
  logic [TAG_W-1:0]   firstTag;

  assign validVec = validQ;
  assign chkLo    = {1'b0, chkAddr};
  assign chkHi    = chkLo + spanOf(chkSize);

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    logic [EXT_W-1:0] entLo, entHi;
    assign entLo     = {1'b0, entAddr[i]};
    assign entHi     = entLo + spanOf(entSize[i]);
    assign hitVec[i] = stb.chkEn && validQ[i] && (chkLo < entHi) && (entLo < chkHi);
    assign tagHit[i] = validQ[i] && (entTag[i] == clrTag);

    always_ff @(posedge clk) begin
      if (stb.wrEn && wrOh[i]) begin
        entAddr[i] <= protAddr;
        entSize[i] <= protSize;
        entTag[i]  <= protTag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
    end else begin
      for (int i = 0; i < NUM_ENT; i++) begin
        if (stb.clrAll)                      validQ[i] <= 1'b0;
        else if (stb.wrEn && wrOh[i])        validQ[i] <= 1'b1;
        else if (stb.clrTagEn && tagHit[i])  validQ[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    firstTag = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (hitVec[i]) firstTag = entTag[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultValid <= 1'b0;
      faultHits  <= '0;
      faultTag   <= '0;
    end else begin
      faultValid <= |hitVec;
      faultHits  <= hitVec;
      faultTag   <= firstTag;
    end
  end

  a_r6_clear_all_empties: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.clrAll) |-> (validQ == '0));

  a_r2_fault_needs_check: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> $past(stb.chkEn));

  a_r5_hits_from_old_table: assert property (@(posedge clk) disable iff (!rstN)
    ((faultHits & ~$past(validQ)) == '0));

  a_r1_alloc_sets_valid: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.wrEn) |-> ((validQ & $past(wrOh)) != '0));
endmodule

// File: rtl/load_alias_table.sv
module load_alias_table
  import alias_pkg::*;
#(
  parameter int NUM_ENT = 8,
  parameter int ADDR_W  = 32,
  parameter int TAG_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               protValid,
  input  logic [ADDR_W-1:0]  protAddr,
  input  logic [1:0]         protSize,
  input  logic [TAG_W-1:0]   protTag,
  input  logic               chkValid,
  input  logic [ADDR_W-1:0]  chkAddr,
  input  logic [1:0]         chkSize,
  input  logic               clrValid,
  input  logic [TAG_W-1:0]   clrTag,
  input  logic               clrAll,
  output logic               faultValid,
  output logic [NUM_ENT-1:0] faultHits,
  output logic [TAG_W-1:0]   faultTag,
  output logic               overflow
);
  strobe_t            stb;
  logic [NUM_ENT-1:0] wrOh;
  logic [NUM_ENT-1:0] validVec;

  alias_ctrl #(.NUM_ENT(NUM_ENT)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .protValid(protValid), .chkValid(chkValid),
    .clrValid(clrValid), .clrAll(clrAll),
    .validVec(validVec), .stb(stb), .wrOh(wrOh), .overflow(overflow)
  );

  alias_dp #(.NUM_ENT(NUM_ENT), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrOh(wrOh),
    .protAddr(protAddr), .protSize(protSize), .protTag(protTag),
    .chkAddr(chkAddr), .chkSize(chkSize), .clrTag(clrTag),
    .validVec(validVec), .faultValid(faultValid),
    .faultHits(faultHits), .faultTag(faultTag)
  );
endmodule

// File: tb/load_alias_table_test.sv
module load_alias_table_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        protValid, chkValid, clrValid, clrAll;
  logic [31:0] protAddr, chkAddr;
  logic [1:0]  protSize, chkSize;
  logic [2:0]  protTag, clrTag;
  logic        faultValid, overflow;
  logic [7:0]  faultHits;
  logic [2:0]  faultTag;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  load_alias_table uut (
    .clk(clk), .rstN(rstN),
    .protValid(protValid), .protAddr(protAddr), .protSize(protSize), .protTag(protTag),
    .chkValid(chkValid), .chkAddr(chkAddr), .chkSize(chkSize),
    .clrValid(clrValid), .clrTag(clrTag), .clrAll(clrAll),
    .faultValid(faultValid), .faultHits(faultHits), .faultTag(faultTag),
    .overflow(overflow)
  );

  typedef struct packed {
    logic       pV;
    logic [31:0] pA;
    logic [1:0] pS;
    logic [2:0] pT;
    logic       cV;
    logic [31:0] cA;
    logic [1:0] cS;
    logic       ca;
    logic       eF;
    logic [7:0] eH;
    logic [2:0] eT;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h100, 2'd2, 3'd5, 1'b0, 32'h0,   2'd0, 1'b0, 1'b0, 8'h00, 3'd0, 4'd1}, // R1 entry0
    '{1'b0, 32'h0,   2'd0, 3'd0, 1'b1, 32'h104, 2'd2, 1'b0, 1'b0, 8'h00, 3'd0, 4'd3}, // R3 touch above
    '{1'b0, 32'h0,   2'd0, 3'd0, 1'b1, 32'h0FC, 2'd2, 1'b0, 1'b0, 8'h00, 3'd0, 4'd3}, // R3 touch below
    '{1'b0, 32'h0,   2'd0, 3'd0, 1'b1, 32'h103, 2'd0, 1'b0, 1'b1, 8'h01, 3'd5, 4'd2}, // R2 last byte
    '{1'b1, 32'h200, 2'd3, 3'd2, 1'b1, 32'h204, 2'd0, 1'b0, 1'b0, 8'h00, 3'd0, 4'd5}, // R5 same cycle
    '{1'b0, 32'h0,   2'd0, 3'd0, 1'b1, 32'h1FE, 2'd2, 1'b0, 1'b1, 8'h02, 3'd2, 4'd2}, // R2 partial
    '{1'b1, 32'h100, 2'd0, 3'd3, 1'b0, 32'h0,   2'd0, 1'b0, 1'b0, 8'h00, 3'd0, 4'd1}, // R1 entry2
    '{1'b0, 32'h0,   2'd0, 3'd0, 1'b1, 32'h0FF, 2'd1, 1'b0, 1'b1, 8'h05, 3'd5, 4'd4}, // R4 two hits
    '{1'b0, 32'h0,   2'd0, 3'd0, 1'b1, 32'h100, 2'd3, 1'b1, 1'b1, 8'h05, 3'd5, 4'd5}, // R5 check vs clear
    '{1'b0, 32'h0,   2'd0, 3'd0, 1'b1, 32'h100, 2'd3, 1'b0, 1'b0, 8'h00, 3'd0, 4'd6}, // R6 emptied
    '{1'b0, 32'h0,   2'd0, 3'd0, 1'b1, 32'h200, 2'd3, 1'b0, 1'b0, 8'h00, 3'd0, 4'd6}  // R6 emptied
  };

  task automatic idle();
    protValid = 1'b0; protAddr = '0; protSize = '0; protTag = '0;
    chkValid  = 1'b0; chkAddr  = '0; chkSize  = '0;
    clrValid  = 1'b0; clrTag   = '0; clrAll   = 1'b0;
  endtask

  task automatic op(input logic pV, input logic [31:0] pA, input logic [1:0] pS,
                    input logic [2:0] pT, input logic cV, input logic [31:0] cA,
                    input logic [1:0] cS, input logic clV, input logic [2:0] clT,
                    input logic ca);
    protValid = pV; protAddr = pA; protSize = pS; protTag = pT;
    chkValid  = cV; chkAddr  = cA; chkSize  = cS;
    clrValid  = clV; clrTag  = clT; clrAll  = ca;
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic probe(input logic [31:0] a, input logic [1:0] s);
    op(1'b0, 32'h0, 2'd0, 3'd0, 1'b1, a, s, 1'b0, 3'd0, 1'b0);
  endtask

  task automatic expect_out(input string req, input logic eF, input logic [7:0] eH,
                            input logic [2:0] eT, input logic eO);
    total++;
    if (faultValid !== eF || faultHits !== eH || faultTag !== eT || overflow !== eO) begin
      bad++;
      $display("FAIL %s: fault=%b hits=%h tag=%0d ovf=%b, expected fault=%b hits=%h tag=%0d ovf=%b",
               req, faultValid, faultHits, faultTag, overflow, eF, eH, eT, eO);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    expect_out("R10", 1'b0, 8'h00, 3'd0, 1'b0);
    rstN = 1'b1;
    probe(32'h0, 2'd3);
    expect_out("R10", 1'b0, 8'h00, 3'd0, 1'b0);

    for (int k = 0; k < NV; k++) begin
      op(VECS[k].pV, VECS[k].pA, VECS[k].pS, VECS[k].pT, VECS[k].cV, VECS[k].cA,
         VECS[k].cS, 1'b0, 3'd0, VECS[k].ca);
      expect_out($sformatf("R%0d row%0d", VECS[k].req, k), VECS[k].eF, VECS[k].eH,
                 VECS[k].eT, 1'b0);
    end

    // R8 fill the table, then one more protect overflows
    for (int i = 0; i < 8; i++) begin
      op(1'b1, 32'h1000 + 32'(16 * i), 2'd0, 3'(i), 1'b0, 32'h0, 2'd0, 1'b0, 3'd0, 1'b0);
    end
    expect_out("R8 full no ovf", 1'b0, 8'h00, 3'd0, 1'b0);
    op(1'b1, 32'h2000, 2'd0, 3'd7, 1'b0, 32'h0, 2'd0, 1'b0, 3'd0, 1'b0);
    expect_out("R8 overflow", 1'b0, 8'h00, 3'd0, 1'b1);
    probe(32'h2000, 2'd0);
    expect_out("R8 dropped", 1'b0, 8'h00, 3'd0, 1'b0);
    probe(32'h1070, 2'd0);
    expect_out("R1 slot7", 1'b1, 8'h80, 3'd7, 1'b0);
    probe(32'h1000, 2'd3);
    expect_out("R1 slot0", 1'b1, 8'h01, 3'd0, 1'b0);

    // R7 clear by tag, then reuse of the freed slot
    op(1'b0, 32'h0, 2'd0, 3'd0, 1'b0, 32'h0, 2'd0, 1'b1, 3'd3, 1'b0);
    probe(32'h1030, 2'd0);
    expect_out("R7 cleared", 1'b0, 8'h00, 3'd0, 1'b0);
    op(1'b1, 32'h3000, 2'd1, 3'd6, 1'b0, 32'h0, 2'd0, 1'b0, 3'd0, 1'b0);
    probe(32'h3001, 2'd0);
    expect_out("R1 reuse slot3", 1'b1, 8'h08, 3'd6, 1'b0);
    op(1'b0, 32'h0, 2'd0, 3'd0, 1'b0, 32'h0, 2'd0, 1'b1, 3'd6, 1'b0);
    probe(32'h3000, 2'd0);
    expect_out("R7 both tag6 a", 1'b0, 8'h00, 3'd0, 1'b0);
    probe(32'h1060, 2'd0);
    expect_out("R7 both tag6 b", 1'b0, 8'h00, 3'd0, 1'b0);

    // R6 clear-all discards a protect in the same cycle
    op(1'b1, 32'h4000, 2'd3, 3'd1, 1'b0, 32'h0, 2'd0, 1'b0, 3'd0, 1'b1);
    probe(32'h4000, 2'd3);
    expect_out("R6 protect dropped", 1'b0, 8'h00, 3'd0, 1'b0);
    probe(32'h1070, 2'd0);
    expect_out("R6 all gone", 1'b0, 8'h00, 3'd0, 1'b0);

    // R9 top of address space
    op(1'b1, 32'hFFFF_FFF8, 2'd3, 3'd4, 1'b0, 32'h0, 2'd0, 1'b0, 3'd0, 1'b0);
    probe(32'hFFFF_FFFC, 2'd2);
    expect_out("R9 top hit", 1'b1, 8'h01, 3'd4, 1'b0);
    probe(32'h0, 2'd3);
    expect_out("R9 no wrap", 1'b0, 8'h00, 3'd0, 1'b0);
    probe(32'hFFFF_FFF0, 2'd3);
    expect_out("R3 touch top", 1'b0, 8'h00, 3'd0, 1'b0);
    probe(32'hFFFF_FFF8, 2'd0);
    expect_out("R3 still held", 1'b1, 8'h01, 3'd4, 1'b0);

    // R7 clear by tag with same-tag allocation in the same cycle
    op(1'b1, 32'h5000, 2'd2, 3'd4, 1'b0, 32'h0, 2'd0, 1'b1, 3'd4, 1'b0);
    probe(32'hFFFF_FFF8, 2'd3);
    expect_out("R7 old gone", 1'b0, 8'h00, 3'd0, 1'b0);
    probe(32'h5002, 2'd0);
    expect_out("R7 new kept", 1'b1, 8'h02, 3'd4, 1'b0);

    // R5 protect and check on the same edge
    op(1'b1, 32'h6000, 2'd0, 3'd2, 1'b1, 32'h6000, 2'd0, 1'b0, 3'd0, 1'b0);
    expect_out("R5 own cycle", 1'b0, 8'h00, 3'd0, 1'b0);
    probe(32'h6000, 2'd0);
    expect_out("R5 next cycle", 1'b1, 8'h01, 3'd2, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule